// File: doc/BRIEF.md
# Translation Cache With Flush

This block keeps a small, fully associative store of recent translations from virtual page numbers to physical frame numbers. It sits between a requester and an external page-table walker. The requester presents a 20-bit virtual page number; the byte offset within the page never enters the block and is appended by the requester. When a valid entry matches, the frame number comes back combinationally in the same cycle. No walker traffic is generated.

When no entry matches, the block captures the page number and drops its ready signal. It holds a request to the walker until the walker answers. A successful answer is written into an entry, and the captured lookup is replayed in the following cycle, where it hits. A faulting answer writes nothing and is passed straight back to the requester. A write of the address-space root pointer, signalled by a one-cycle pulse, clears every entry at once. New translations are placed in an empty slot if one exists; otherwise they go to the slot under a round-robin pointer.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid, `lkp_ready` is 1, and both `walk_req` and `lkp_resp_valid` are 0; the first lookup of any page after reset misses.
- R2: A lookup accepted in IDLE that matches a valid entry raises `lkp_resp_valid` in the same cycle, with `lkp_resp_fault`=0 and `lkp_resp_pfn` equal to the stored frame. No walk is requested.
- R3: A lookup that misses raises `walk_req` from the next cycle with `walk_vpn` equal to the missed page number. Both hold until `walk_rsp_valid` is seen.
- R4: While a miss is outstanding, `lkp_ready` is 0 and any lookup presented is ignored; it does not change `walk_vpn` and produces no response.
- R5: A walker answer with `walk_rsp_fault`=0 installs the frame. In the next cycle, the replayed lookup raises `lkp_resp_valid` with that frame, and later lookups of the page hit.
- R6: A walker answer with `walk_rsp_fault`=1 raises `lkp_resp_valid` and `lkp_resp_fault` in the same cycle. It installs nothing, so a repeat lookup of the page misses again.
- R7: A cycle with `root_wr`=1 invalidates every entry. In that cycle `lkp_ready` is 0 and no hit is reported.
- R8: If `root_wr` coincides with a successful walker answer, the answer is dropped. The replay cycle misses and the walk is issued again for the same page.
- R9: An install picks the lowest-numbered invalid slot. When all slots are valid it picks the slot under a round-robin pointer, and the pointer then moves to the slot after the one written. After eight distinct pages fill the store, a ninth evicts the first page filled and keeps the other seven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_wr | input | 1 | Pulse: root page-table pointer rewritten, flush all entries |
| lkp_valid | input | 1 | Lookup request present |
| lkp_vpn | input | 20 | Virtual page number to translate |
| lkp_ready | output | 1 | Lookup accepted this cycle |
| lkp_resp_valid | output | 1 | Translation or fault result present |
| lkp_resp_pfn | output | 20 | Physical frame number of the result |
| lkp_resp_fault | output | 1 | Result is a walker fault |
| walk_req | output | 1 | Refill request to the walker |
| walk_vpn | output | 20 | Page number the walker must resolve |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_pfn | input | 20 | Frame number returned by the walker |
| walk_rsp_fault | input | 1 | Walker found no mapping |

## Verification
Several properties are checked on every cycle. At most one entry may match a page. The walk request and its page number must stay steady until answered. The ready signal must stay low behind an outstanding miss. A flush must leave every entry invalid, and a fault must leave the valid bits untouched. A successful refill must be followed by a response or a flush. The victim slot must be invalid whenever any slot is. Frame values, the exact eviction order over a full store, the same-cycle hit, the ignored lookups during a miss, and a flush landing on a refill are only visible in the bench's scenarios. Each of these is compared against a walker model in the bench.

// File: rtl/xc_pkg.sv
// Shared types for the translation cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package xc_pkg;
    typedef enum logic [1:0] {
        XC_IDLE  = 2'd0,
        XC_WALK  = 2'd1,
        XC_RETRY = 2'd2
    } xc_state_e;
endpackage

// File: rtl/xc_tag_array.sv
// Fully associative entry store: valid bits, page tags, frame numbers.
// Compares one page number against all entries every cycle. Writes one
// entry per install and clears every valid bit on flush. Assumes the
// controller installs only pages that currently miss.
module xc_tag_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   look_vpn,
    output logic               hit,
    output logic [PFN_W-1:0]   hit_pfn,
    input  logic               install,
    input  logic [IDX_W-1:0]   install_idx,
    input  logic [VPN_W-1:0]   install_vpn,
    input  logic [PFN_W-1:0]   install_pfn,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Per-slot storage: reset/flush clear valid, install writes the slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_vec[g] <= 1'b0;
            end else if (install && install_idx == IDX_W'(g)) begin
                valid_vec[g] <= 1'b1;
                tag_q[g]     <= install_vpn;
                pfn_q[g]     <= install_pfn;
            end
        end
        // Per-slot comparator.
        assign match[g] = valid_vec[g] && (tag_q[g] == look_vpn);
    end

    // Merge matching frames; at most one slot matches.
    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    assign hit = |match;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0)); // R7
endmodule

// File: rtl/xc_victim_sel.sv
// Replacement choice: lowest invalid slot first, else round-robin pointer.
// The pointer moves past each written slot and returns to zero on flush.
module xc_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               install,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] ptr_q;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    // Scan from the top so the lowest free index wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim = free_found ? free_idx : ptr_q;

    // Round-robin pointer: step past the written slot, wrap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (install) begin
            ptr_q <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
        end
    end

    AST_PREFER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != '1) |-> !valid_vec[victim]); // R9
endmodule

// File: rtl/xc_ctrl.sv
// Miss controller: accepts lookups in IDLE, captures a missed page, holds
// the walker request, installs or forwards the answer, replays the lookup.
// Assumes the walker answers once per request and root_wr is a pulse.
module xc_ctrl
    import xc_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lkp_valid,
    input  logic [VPN_W-1:0] lkp_vpn,
    output logic             lkp_ready,
    output logic             resp_valid,
    output logic             resp_fault,
    input  logic             hit,
    output logic [VPN_W-1:0] look_vpn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_fault,
    output logic             install
);
    xc_state_e        state_q, state_d;
    logic [VPN_W-1:0] pend_q;
    logic             hit_ok;
    logic             rsp_seen;

    assign hit_ok    = hit && !flush;
    assign rsp_seen  = (state_q == XC_WALK) && walk_rsp_valid;
    assign lkp_ready = (state_q == XC_IDLE) && !flush;
    assign look_vpn  = (state_q == XC_IDLE) ? lkp_vpn : pend_q;
    assign walk_req  = (state_q == XC_WALK);
    assign walk_vpn  = pend_q;
    assign install   = rsp_seen && !walk_rsp_fault && !flush;
    assign resp_fault = rsp_seen && walk_rsp_fault;

    // Response: same-cycle hit, replay hit, or forwarded fault.
    always_comb begin
        unique case (state_q)
            XC_IDLE:  resp_valid = lkp_valid && hit_ok;
            XC_RETRY: resp_valid = hit_ok;
            XC_WALK:  resp_valid = walk_rsp_valid && walk_rsp_fault;
            default:  resp_valid = 1'b0;
        endcase
    end

    // Next state of the miss handler.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XC_IDLE:  if (lkp_valid && !flush && !hit) state_d = XC_WALK;
            XC_WALK:  if (walk_rsp_valid) state_d = walk_rsp_fault ? XC_IDLE : XC_RETRY;
            XC_RETRY: state_d = hit_ok ? XC_IDLE : XC_WALK;
            default:  state_d = XC_IDLE;
        endcase
    end

    // State register and captured page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XC_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == XC_IDLE && state_d == XC_WALK) pend_q <= lkp_vpn;
        end
    end

    AST_WALK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_rsp_valid) |=> (walk_req && $stable(walk_vpn))); // R3
    AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_rsp_valid) |=> !lkp_ready); // R4
    AST_FAULT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> resp_valid); // R6
endmodule

// File: rtl/xlate_cache.sv
// Top of the translation cache: wires the entry store, victim selector and
// miss controller. Frame output is zero on a fault response.
// Assumes a single requester and a single walker.
module xlate_cache #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             root_wr,
    input  logic             lkp_valid,
    input  logic [VPN_W-1:0] lkp_vpn,
    output logic             lkp_ready,
    output logic             lkp_resp_valid,
    output logic [PFN_W-1:0] lkp_resp_pfn,
    output logic             lkp_resp_fault,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    input  logic             walk_rsp_fault
);
    logic               hit;
    logic [PFN_W-1:0]   hit_pfn;
    logic [VPN_W-1:0]   look_vpn;
    logic               install;
    logic [IDX_W-1:0]   victim;
    logic [ENTRIES-1:0] valid_vec;

    xc_ctrl #(.VPN_W(VPN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(root_wr),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_ready(lkp_ready),
        .resp_valid(lkp_resp_valid), .resp_fault(lkp_resp_fault),
        .hit(hit), .look_vpn(look_vpn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
        .install(install)
    );

    xc_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
        .clk(clk), .rst_n(rst_n), .flush(root_wr),
        .look_vpn(look_vpn), .hit(hit), .hit_pfn(hit_pfn),
        .install(install), .install_idx(victim),
        .install_vpn(walk_vpn), .install_pfn(walk_rsp_pfn),
        .valid_vec(valid_vec)
    );

    xc_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(root_wr), .install(install),
        .valid_vec(valid_vec), .victim(victim)
    );

    assign lkp_resp_pfn = lkp_resp_fault ? '0 : hit_pfn;

    AST_FAULT_NO_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_rsp_valid && walk_rsp_fault && !root_wr) |=> $stable(valid_vec)); // R6
    AST_REFILL_REPLAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_rsp_valid && !walk_rsp_fault && !root_wr) |=> (lkp_resp_valid || root_wr)); // R5
endmodule

// File: tb/tb_xlate_cache.sv
// Self-checking bench: a vector table of lookups walked by one loop, then
// directed tests for flush, flush during refill, and reset.
module tb_xlate_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_wr = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [19:0] lkp_vpn = '0;
    logic        lkp_ready;
    logic        lkp_resp_valid;
    logic [19:0] lkp_resp_pfn;
    logic        lkp_resp_fault;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_rsp_valid = 1'b0;
    logic [19:0] walk_rsp_pfn = '0;
    logic        walk_rsp_fault = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlate_cache dut (
        .clk(clk), .rst_n(rst_n), .root_wr(root_wr),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_ready(lkp_ready),
        .lkp_resp_valid(lkp_resp_valid), .lkp_resp_pfn(lkp_resp_pfn),
        .lkp_resp_fault(lkp_resp_fault),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
        .walk_rsp_fault(walk_rsp_fault)
    );

    // Walker model: frame derived from page; top nibble F means unmapped.
    function automatic logic [19:0] pfn_of(input logic [19:0] v);
        return {v[9:0], v[19:10]} ^ 20'h3C3C3;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One lookup; on a miss, play the walker with a 2-cycle delay.
    task automatic run_lookup(input logic [19:0] v, input bit exp_hit, input bit exp_fault);
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_vpn   = v;
        #1;
        chk(lkp_ready, "R4 ready in idle", 32'(lkp_ready), 1);
        if (exp_hit) begin
            chk(lkp_resp_valid && !lkp_resp_fault && lkp_resp_pfn == pfn_of(v),
                "R2 same-cycle hit", {lkp_resp_valid, 11'd0, lkp_resp_pfn}, {1'b1, 11'd0, pfn_of(v)});
            chk(!walk_req, "R2 no walk on hit", 32'(walk_req), 0);
            @(negedge clk);
            lkp_valid = 1'b0;
        end else begin
            chk(!lkp_resp_valid, "R3 miss gives no response", 32'(lkp_resp_valid), 0);
            @(negedge clk);
            lkp_vpn = v ^ 20'h00001;   // R4: must be ignored
            #1;
            chk(walk_req && walk_vpn == v, "R3 walk request", {walk_req, 11'd0, walk_vpn}, {1'b1, 11'd0, v});
            chk(!lkp_ready && !lkp_resp_valid, "R4 blocked during miss",
                {lkp_ready, lkp_resp_valid}, 0);
            @(negedge clk);
            lkp_valid = 1'b0;
            #1;
            chk(walk_req && walk_vpn == v, "R3 walk held", {walk_req, 11'd0, walk_vpn}, {1'b1, 11'd0, v});
            @(negedge clk);
            walk_rsp_valid = 1'b1;
            walk_rsp_pfn   = exp_fault ? 20'h0 : pfn_of(v);
            walk_rsp_fault = exp_fault;
            #1;
            if (exp_fault)
                chk(lkp_resp_valid && lkp_resp_fault, "R6 fault forwarded",
                    {lkp_resp_valid, lkp_resp_fault}, 3);
            @(negedge clk);
            walk_rsp_valid = 1'b0;
            walk_rsp_fault = 1'b0;
            #1;
            if (exp_fault)
                chk(!lkp_resp_valid && lkp_ready, "R6 back to idle", {lkp_resp_valid, lkp_ready}, 1);
            else
                chk(lkp_resp_valid && !lkp_resp_fault && lkp_resp_pfn == pfn_of(v),
                    "R5 replay hits", {lkp_resp_valid, 11'd0, lkp_resp_pfn}, {1'b1, 11'd0, pfn_of(v)});
        end
    endtask

    // {hit, fault, vpn}: fill, hit all, evict first (R9), faults (R6).
    localparam logic [21:0] TBL [24] = '{
        {2'b00, 20'h10000}, {2'b00, 20'h10111}, {2'b00, 20'h10222}, {2'b00, 20'h10333},
        {2'b00, 20'h10444}, {2'b00, 20'h10555}, {2'b00, 20'h10666}, {2'b00, 20'h10777},
        {2'b10, 20'h10000}, {2'b10, 20'h10111}, {2'b10, 20'h10222}, {2'b10, 20'h10333},
        {2'b10, 20'h10444}, {2'b10, 20'h10555}, {2'b10, 20'h10666}, {2'b10, 20'h10777},
        {2'b00, 20'h10888}, {2'b10, 20'h10888}, {2'b10, 20'h10777}, {2'b00, 20'h10000},
        {2'b10, 20'h10222}, {2'b00, 20'h10111}, {2'b01, 20'hF0001}, {2'b01, 20'hF0001}
    };

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(lkp_ready && !walk_req && !lkp_resp_valid, "R1 reset state",
            {lkp_ready, walk_req, lkp_resp_valid}, 3'b100);

        // R9 R2 R3 R5 R6: table walk
        foreach (TBL[i]) run_lookup(TBL[i][19:0], TBL[i][21], TBL[i][20]);

        // R7: flush with a lookup of a cached page present
        @(negedge clk);
        root_wr = 1'b1; lkp_valid = 1'b1; lkp_vpn = 20'h10888;
        #1;
        chk(!lkp_ready && !lkp_resp_valid, "R7 flush cycle blocks", {lkp_ready, lkp_resp_valid}, 0);
        @(negedge clk);
        root_wr = 1'b0; lkp_valid = 1'b0;
        run_lookup(20'h10888, 1'b0, 1'b0);   // R7 misses after flush
        run_lookup(20'h10888, 1'b1, 1'b0);

        // R8: flush lands on a successful walker answer
        @(negedge clk);
        lkp_valid = 1'b1; lkp_vpn = 20'h10333;
        @(negedge clk);
        lkp_valid = 1'b0;
        walk_rsp_valid = 1'b1; walk_rsp_pfn = pfn_of(20'h10333); root_wr = 1'b1;
        #1;
        chk(!lkp_resp_valid, "R8 no response on dropped refill", 32'(lkp_resp_valid), 0);
        @(negedge clk);
        walk_rsp_valid = 1'b0; root_wr = 1'b0;
        #1;
        chk(!lkp_resp_valid && !walk_req, "R8 replay misses", {lkp_resp_valid, walk_req}, 0);
        @(negedge clk);
        #1;
        chk(walk_req && walk_vpn == 20'h10333, "R8 walk reissued", {walk_req, 11'd0, walk_vpn}, {1'b1, 11'd0, 20'h10333});
        @(negedge clk);
        walk_rsp_valid = 1'b1;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
        #1;
        chk(lkp_resp_valid && lkp_resp_pfn == pfn_of(20'h10333), "R8 second refill replays",
            {lkp_resp_valid, 11'd0, lkp_resp_pfn}, {1'b1, 11'd0, pfn_of(20'h10333)});
        run_lookup(20'h10333, 1'b1, 1'b0);

        // R1: reset clears entries
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_lookup(20'h10333, 1'b0, 1'b0);   // R1 first lookup misses

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule